// File: doc/BRIEF.md
# Oversampled Serial Receiver with Deferred Overrun Reporting

This block is the receive side of a small processor's serial port. It watches a single serial line using a baud tick that runs at sixteen times the bit rate. When it sees a start bit, it collects eight data bits, least significant bit first, and then checks the stop bit. A finished character is copied into a holding register, where the processor reads it with a one-cycle read strobe.

Three flags describe the character in the holding register: *done* (a character is waiting), *frame error* (its stop bit was low) and *overrun* (a later character was lost). The overrun flag is deferred. It appears only after the processor has read the character that was still valid when the later one arrived. An interrupt request is raised while *done* is set, but only if both the local enable and the global enable are high. A receive-enable input stops reception completely. While it is low, no flag can become set, and flags that are already set keep their values.

Top module: `uart_rx_core`

## Requirements
- R1: A start bit is accepted only if the line is still low on the 8th baud tick after the falling edge was first seen. A low pulse that returns high before then produces no character.
- R2: Each data bit is sampled 16 ticks after the previous sample, least significant bit first. The assembled byte appears on `data_out`.
- R3: The done flag sets when a character is moved into the holding register. It clears on the cycle after a `rd_data` strobe.
- R4: The frame error flag is set when a moved character had a stop bit of 0. It is cleared when a moved character had a stop bit of 1. The character is moved either way.
- R5: If a character completes while the done flag is still set, it is discarded. The held byte and the done flag stay unchanged.
- R6: After an overrun, the overrun flag reads 0 until `rd_data` reads the held byte, and reads 1 after that read. It clears when a later character is moved without overrun.
- R7: While `rx_en` is 0, no character is received and none of the done, frame error or overrun flags can become set. Dropping `rx_en` leaves flags that are already set unchanged.
- R8: `irq` equals done AND `rxc_ie` AND `gie`.
- R9: `status_out` bit 7 is done, bit 4 is frame error and bit 3 is overrun. All other bits, including bits 2 to 0, always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receiver enable |
| rxc_ie | input | 1 | Receive-complete interrupt enable |
| gie | input | 1 | Global interrupt enable |
| rd_data | input | 1 | Read strobe for the holding register |
| data_out | output | 8 | Holding register |
| status_out | output | 8 | Status flags (see R9) |
| irq | output | 1 | Receive-complete interrupt request |

## Verification
The stop bit is sampled on a baud tick. The completion pulse is registered on that edge, and the flags and holding register update on the next clock edge. The bench therefore waits at least twenty idle cycles after each frame before it checks anything. A read strobe takes effect on the clock edge where it is high, so flags are checked one full cycle after the strobe is removed. `irq` is combinational from the flags and the enables, so it is checked one cycle after an enable changes.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_state_e;

  // status word layout: done[7], frame error[4], overrun[3]
  function automatic logic [7:0] pack_status(input logic done, input logic ferr, input logic ovr);
    logic [7:0] s;
    s = 8'h00;
    s[7] = done;
    s[4] = ferr;
    s[3] = ovr;
    return s;
  endfunction

  function automatic logic irq_request(input logic done, input logic ie, input logic g);
    return done & ie & g;
  endfunction
endpackage

// File: rtl/rx_bit_sampler.sv
module rx_bit_sampler
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rxd,
  input  logic              rx_en,
  output logic              char_done,
  output logic [DATA_W-1:0] char_data,
  output logic              char_stop
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(DATA_W - 1);

  rx_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  bit_idx;
  logic [DATA_W-1:0] shreg;
  logic              done_q;
  logic              stop_q;
  logic [DATA_W-1:0] data_q;

  // named internal events
  logic start_check, start_false, bit_sample;
  assign start_check = (st == S_START) && baud_tick && (cnt == MID_CNT);
  assign start_false = start_check && rxd;
  assign bit_sample  = ((st == S_DATA) || (st == S_STOP)) && baud_tick && (cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      done_q  <= 1'b0;
      stop_q  <= 1'b1;
      data_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!rx_en) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else if (baud_tick) begin
        case (st)
          S_IDLE: begin
            if (!rxd) begin
              st  <= S_START;
              cnt <= CNT_W'(1);
            end
          end
          S_START: begin
            if (start_check) begin
              st      <= start_false ? S_IDLE : S_DATA;
              cnt     <= '0;
              bit_idx <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (bit_sample) begin
              shreg <= {rxd, shreg[DATA_W-1:1]};
              cnt   <= '0;
              if (bit_idx == LAST_BIT) st <= S_STOP;
              else bit_idx <= bit_idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (bit_sample) begin
              done_q <= 1'b1;
              stop_q <= rxd;
              data_q <= shreg;
              st     <= S_IDLE;
              cnt    <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign char_done = done_q;
  assign char_data = data_q;
  assign char_stop = stop_q;

  // R1
  start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && start_false) |=> (st == S_IDLE && !char_done));

  // R2
  done_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |-> $past(st) == S_STOP);

  // R7
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (st == S_IDLE && !char_done));
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              char_done,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_stop,
  input  logic              rd_data,
  output logic [DATA_W-1:0] hold_data,
  output logic              done_flag,
  output logic              ferr_flag,
  output logic              ovr_flag
);
  logic [DATA_W-1:0] data_q;
  logic rxc_q, fe_q, ovr_q, ovr_pend;

  // named internal events
  logic accept_evt, overrun_evt;
  assign accept_evt  = rx_en && char_done && (!rxc_q || rd_data);
  assign overrun_evt = rx_en && char_done && rxc_q && !rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q   <= '0;
      rxc_q    <= 1'b0;
      fe_q     <= 1'b0;
      ovr_q    <= 1'b0;
      ovr_pend <= 1'b0;
    end else begin
      if (rd_data) begin
        rxc_q <= 1'b0;
        if (ovr_pend && rx_en) begin
          ovr_q    <= 1'b1;
          ovr_pend <= 1'b0;
        end
      end
      if (overrun_evt) ovr_pend <= 1'b1;
      if (accept_evt) begin
        data_q   <= char_data;
        rxc_q    <= 1'b1;
        fe_q     <= ~char_stop;
        ovr_q    <= 1'b0;
        ovr_pend <= 1'b0;
      end
    end
  end

  assign hold_data = data_q;
  assign done_flag = rxc_q;
  assign ferr_flag = fe_q;
  assign ovr_flag  = ovr_q;

  // R5
  keep_on_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> ($stable(data_q) && rxc_q));

  // R3
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !char_done) |=> !rxc_q);

  // R7
  frozen_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rxc_q) |=> !rxc_q);

  // R7
  frozen_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && fe_q) |=> fe_q);

  // R6
  ovr_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(rd_data));
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic              rxc_ie,
  input  logic              gie,
  input  logic              rd_data,
  output logic [DATA_W-1:0] data_out,
  output logic [7:0]        status_out,
  output logic              irq
);
  logic              char_done, char_stop;
  logic [DATA_W-1:0] char_data;
  logic              done_flag, ferr_flag, ovr_flag;

  rx_bit_sampler #(.DATA_W(DATA_W), .OVS(OVS)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .rxd       (rxd),
    .rx_en     (rx_en),
    .char_done (char_done),
    .char_data (char_data),
    .char_stop (char_stop)
  );

  rx_status_regs #(.DATA_W(DATA_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .char_done (char_done),
    .char_data (char_data),
    .char_stop (char_stop),
    .rd_data   (rd_data),
    .hold_data (data_out),
    .done_flag (done_flag),
    .ferr_flag (ferr_flag),
    .ovr_flag  (ovr_flag)
  );

  assign status_out = pack_status(done_flag, ferr_flag, ovr_flag);
  assign irq        = irq_request(done_flag, rxc_ie, gie);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rxc_ie && gie && status_out[7]));

  // R9
  status_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_out & 8'b0110_0111) == 8'h00);
endmodule

// File: tb/uart_rx_core_bench.sv
module uart_rx_core_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic rxd = 1'b1;
  logic rx_en = 1'b1;
  logic rxc_ie = 1'b0;
  logic gie = 1'b0;
  logic rd_data = 1'b0;
  logic [7:0] data_out;
  logic [7:0] status_out;
  logic irq;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) baud_tick <= 1'b0;
    else baud_tick <= ~baud_tick;
  end

  uart_rx_core u_uart_rx_core (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .rx_en(rx_en), .rxc_ie(rxc_ie), .gie(gie), .rd_data(rd_data),
    .data_out(data_out), .status_out(status_out), .irq(irq)
  );

  // expected status word, built bit by bit
  function automatic logic [7:0] exp_stat(input logic d, input logic f, input logic o);
    return {d, 2'b00, f, o, 3'b000};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // 32 cycles per bit = 16 baud ticks
  task automatic send_frame(input logic [7:0] d, input logic stop);
    rxd = 1'b0;
    wait_cyc(32);
    for (int b = 0; b < 8; b++) begin
      rxd = d[b];
      wait_cyc(32);
    end
    rxd = stop;
    wait_cyc(20);
    rxd = 1'b1;
    wait_cyc(44);
  endtask

  task automatic do_read();
    rd_data = 1'b1;
    wait_cyc(1);
    rd_data = 1'b0;
    wait_cyc(1);
  endtask

  // {data, stop bit}
  localparam logic [8:0] VEC [6] = '{
    {8'hA5, 1'b1}, {8'h3C, 1'b0}, {8'h00, 1'b1},
    {8'hFF, 1'b1}, {8'h81, 1'b0}, {8'h5A, 1'b1}
  };

  initial begin
    wait_cyc(100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_cyc(4);
    check("R9 reset status", status_out, 8'h00);
    check("R3 reset data", data_out, 8'h00);
    check("R8 reset irq", irq, 1'b0);
    rst_n = 1'b1;
    wait_cyc(10);

    // table walk: R2, R3, R4, R9
    for (int i = 0; i < 6; i++) begin
      logic [7:0] d;
      logic s;
      d = VEC[i][8:1];
      s = VEC[i][0];
      send_frame(d, s);
      check("R2 data", data_out, d);
      check("R4 status after frame", status_out, exp_stat(1'b1, ~s, 1'b0));
      do_read();
      check("R3 done cleared by read", status_out, exp_stat(1'b0, ~s, 1'b0));
    end

    // R1: short low pulse (4 ticks) gives no character
    rxd = 1'b0;
    wait_cyc(8);
    rxd = 1'b1;
    wait_cyc(400);
    check("R1 glitch ignored status", status_out, exp_stat(1'b0, 1'b0, 1'b0));
    check("R1 glitch ignored data", data_out, 8'h5A);

    // R5 / R6 overrun
    send_frame(8'h11, 1'b1);
    send_frame(8'h22, 1'b1);
    check("R5 held byte kept", data_out, 8'h11);
    check("R6 overrun hidden before read", status_out, exp_stat(1'b1, 1'b0, 1'b0));
    do_read();
    check("R6 overrun visible after read", status_out, exp_stat(1'b0, 1'b0, 1'b1));
    check("R5 byte after read", data_out, 8'h11);
    send_frame(8'h33, 1'b1);
    check("R6 overrun cleared by next byte", status_out, exp_stat(1'b1, 1'b0, 1'b0));
    check("R6 next byte data", data_out, 8'h33);

    // R8 interrupt gating (done is set)
    rxc_ie = 1'b1; gie = 1'b1;
    wait_cyc(1);
    check("R8 irq both enables", irq, 1'b1);
    gie = 1'b0;
    wait_cyc(1);
    check("R8 irq no global", irq, 1'b0);
    gie = 1'b1; rxc_ie = 1'b0;
    wait_cyc(1);
    check("R8 irq no local", irq, 1'b0);
    rxc_ie = 1'b1;
    do_read();
    check("R8 irq after read", irq, 1'b0);
    rxc_ie = 1'b0; gie = 1'b0;

    // R7 freeze on disable
    send_frame(8'h44, 1'b0);
    check("R7 setup status", status_out, exp_stat(1'b1, 1'b1, 1'b0));
    rx_en = 1'b0;
    wait_cyc(4);
    check("R7 flags kept on disable", status_out, exp_stat(1'b1, 1'b1, 1'b0));
    do_read();
    send_frame(8'h77, 1'b1);
    check("R7 no receive when disabled", status_out, exp_stat(1'b0, 1'b1, 1'b0));
    check("R7 data unchanged when disabled", data_out, 8'h44);
    rx_en = 1'b1;
    wait_cyc(4);
    send_frame(8'h99, 1'b1);
    check("R7 receive after re-enable", status_out, exp_stat(1'b1, 1'b0, 1'b0));
    check("R2 data after re-enable", data_out, 8'h99);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule